// File: doc/BRIEF.md
# Buffered Compare Reload Controller

This block keeps the four compare values of an up/down PWM timer. Each channel has a buffer register that the register bus writes and an active register that the comparators read. A small control register chooses how buffer contents reach the active registers. There are two methods.

In simultaneous reload mode, software writes any buffers it needs and then writes channel 1, either at its own address or at an alias address. The write to channel 1 arms a pending reload. At the next selected reload point, all four buffers are copied into the active registers in one clock edge. The reload point is chosen from one of two sources. The first is the counter's peak and valley reload events, each gated by its own enable. The second is the counter's peak and valley interrupt events. In anytime mode, each write reaches its active register immediately.

The counter itself and the PWM output stage are outside this block.

Top module: `cmpReloadTop`

## Requirements
- R1: The control value `ctlVal` is 8 bits and resets to 0x00. A write to address 4 loads `wrData[1:0]` into bits 1:0. Bits 7:2 always read as zero.
- R2: After reset, `reloadPending` is 0 and every buffer and active value is 0.
- R3: In reload mode (bit 0 = 0), a write to address 0, 2 or 3 updates that channel's buffer on the next edge. It does not change any active value and does not set `reloadPending`.
- R4: In reload mode, a write to address 1 or to its alias address 5 updates the channel 1 buffer and sets `reloadPending` on the next edge.
- R5: When `reloadPending` is 1 and a reload point occurs, all four active values take their buffer values on the next edge, and `reloadPending` clears on that same edge.
- R6: With bit 1 = 0, a reload point is `peakEvt & peakReloadEn` or `valleyEvt & valleyReloadEn`. The interrupt pulses are ignored.
- R7: With bit 1 = 1, a reload point is `peakIrqEvt` or `valleyIrqEvt`. The reload pulses and their enables are ignored.
- R8: In anytime mode (bit 0 = 1), a write to a channel address updates both the buffer and the active value of that channel on the next edge. Event pulses have no effect in this mode.
- R9: Writing the control value with bit 0 = 1 clears `reloadPending`. The flag stays 0 while anytime mode is selected.
- R10: If an arming write falls in the same cycle as a reload point, the transfer includes the newly written value, and `reloadPending` is 0 afterwards.
- R11: In reload mode with no pending reload, a reload point leaves the active values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0-3 channels, 4 control, 5 channel 1 alias |
| wrData | input | 16 | Write data |
| peakEvt | input | 1 | Peak reload event pulse |
| valleyEvt | input | 1 | Valley reload event pulse |
| peakReloadEn | input | 1 | Enable for the peak reload event |
| valleyReloadEn | input | 1 | Enable for the valley reload event |
| peakIrqEvt | input | 1 | Peak interrupt event pulse |
| valleyIrqEvt | input | 1 | Valley interrupt event pulse |
| ctlVal | output | 8 | Control register read value |
| reloadPending | output | 1 | Reload armed and not yet performed |
| bufferCmp | output | 64 | Buffer values, channel 0 in bits 15:0 |
| activeCmp | output | 64 | Active values, channel 0 in bits 15:0 |

## Verification
Every result appears exactly one clock edge after its stimulus. This holds for a buffer update, an anytime update of an active value, the arming of the flag and a transfer: each passes through one register stage. The bench holds each stimulus for one cycle and reads the outputs two time units after the following rising edge. It reads them before the next stimulus is applied, so every check sees the state produced by exactly that one stimulus. Ignored pulses are checked by looking at the active values and the pending flag on the cycle after the pulse.

// File: rtl/cmp_reload_pkg.sv
package cmp_reload_pkg;
  parameter int NUM_CH     = 4;
  parameter int CMP_W      = 16;
  parameter int ADDR_W     = 3;
  parameter int ARM_CH     = 1;
  parameter int CTL_ADDR   = 4;
  parameter int ALIAS_ADDR = 5;

  typedef struct packed {
    logic [NUM_CH-1:0] bufWr;
    logic [NUM_CH-1:0] actWr;
    logic              transfer;
  } strobe_t;
endpackage

// File: rtl/cmpReloadCtrl.sv
module cmpReloadCtrl
  import cmp_reload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        ctlData,
  input  logic              peakEvt,
  input  logic              valleyEvt,
  input  logic              peakReloadEn,
  input  logic              valleyReloadEn,
  input  logic              peakIrqEvt,
  input  logic              valleyIrqEvt,
  output logic [1:0]        ctlBits,
  output logic              pendQ,
  output strobe_t           strb
);
  logic [NUM_CH-1:0] hit;
  logic anytime, useIrq, ctlWr, armWr, evtSel;

  assign anytime = ctlBits[0];
  assign useIrq  = ctlBits[1];
  assign ctlWr   = wrEn && (wrAddr == ADDR_W'(CTL_ADDR));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    if (i == ARM_CH) begin : g_arm
      assign hit[i] = wrEn && ((wrAddr == ADDR_W'(i)) || (wrAddr == ADDR_W'(ALIAS_ADDR)));
    end else begin : g_plain
      assign hit[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
  end

  assign armWr  = hit[ARM_CH] && !anytime;
  assign evtSel = useIrq ? (peakIrqEvt || valleyIrqEvt)
                         : ((peakEvt && peakReloadEn) || (valleyEvt && valleyReloadEn));

  always_comb begin
    strb.bufWr    = hit;
    strb.actWr    = anytime ? hit : '0;
    strb.transfer = !anytime && evtSel && (pendQ || armWr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlBits <= 2'b00;
      pendQ   <= 1'b0;
    end else begin
      if (ctlWr) ctlBits <= ctlData;
      if (anytime || (ctlWr && ctlData[0])) pendQ <= 1'b0;
      else if (strb.transfer)               pendQ <= 1'b0;
      else if (armWr)                       pendQ <= 1'b1;
    end
  end
endmodule

// File: rtl/cmpReloadBank.sv
module cmpReloadBank
  import cmp_reload_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [CMP_W-1:0]        wrData,
  output logic [NUM_CH*CMP_W-1:0] bufFlat,
  output logic [NUM_CH*CMP_W-1:0] actFlat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CMP_W-1:0] bufQ, actQ, bufNext;
    assign bufNext = strb.bufWr[i] ? wrData : bufQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ <= '0;
        actQ <= '0;
      end else begin
        bufQ <= bufNext;
        if (strb.transfer)      actQ <= bufNext;
        else if (strb.actWr[i]) actQ <= wrData;
      end
    end

    assign bufFlat[i*CMP_W +: CMP_W] = bufQ;
    assign actFlat[i*CMP_W +: CMP_W] = actQ;
  end
endmodule

// File: rtl/cmpReloadTop.sv
module cmpReloadTop
  import cmp_reload_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [CMP_W-1:0]        wrData,
  input  logic                    peakEvt,
  input  logic                    valleyEvt,
  input  logic                    peakReloadEn,
  input  logic                    valleyReloadEn,
  input  logic                    peakIrqEvt,
  input  logic                    valleyIrqEvt,
  output logic [7:0]              ctlVal,
  output logic                    reloadPending,
  output logic [NUM_CH*CMP_W-1:0] bufferCmp,
  output logic [NUM_CH*CMP_W-1:0] activeCmp
);
  strobe_t    strb;
  logic [1:0] ctlBits;

  cmpReloadCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .ctlData(wrData[1:0]),
    .peakEvt(peakEvt), .valleyEvt(valleyEvt),
    .peakReloadEn(peakReloadEn), .valleyReloadEn(valleyReloadEn),
    .peakIrqEvt(peakIrqEvt), .valleyIrqEvt(valleyIrqEvt),
    .ctlBits(ctlBits), .pendQ(reloadPending), .strb(strb)
  );

  cmpReloadBank bank_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .bufFlat(bufferCmp), .actFlat(activeCmp)
  );

  assign ctlVal = {6'b000000, ctlBits};
endmodule

// File: rtl/cmpReloadChk.sv
module cmpReloadChk
  import cmp_reload_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [ADDR_W-1:0]       wrAddr,
  input logic [CMP_W-1:0]        wrData,
  input logic                    peakEvt,
  input logic                    valleyEvt,
  input logic                    peakReloadEn,
  input logic                    valleyReloadEn,
  input logic                    peakIrqEvt,
  input logic                    valleyIrqEvt,
  input logic [7:0]              ctlVal,
  input logic                    reloadPending,
  input logic [NUM_CH*CMP_W-1:0] bufferCmp,
  input logic [NUM_CH*CMP_W-1:0] activeCmp
);
  logic armWr, relPt, irqPt, pt;
  assign armWr = wrEn && (wrAddr == ADDR_W'(ARM_CH) || wrAddr == ADDR_W'(ALIAS_ADDR));
  assign relPt = (peakEvt && peakReloadEn) || (valleyEvt && valleyReloadEn);
  assign irqPt = peakIrqEvt || valleyIrqEvt;
  assign pt    = ctlVal[1] ? irqPt : relPt;

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == ADDR_W'(CTL_ADDR) |=> ctlVal == {6'b0, $past(wrData[1:0])}); // R1
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[0] && armWr && !pt |=> reloadPending); // R4
  AST_TRANSFER: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[0] && reloadPending && pt && !wrEn |=> activeCmp == $past(bufferCmp) && !reloadPending); // R5
  AST_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[0] && !ctlVal[1] && !armWr && !relPt |=> $stable(activeCmp)); // R6
  AST_REL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[0] && ctlVal[1] && !armWr && !irqPt |=> $stable(activeCmp)); // R7
  AST_ANYTIME_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    ctlVal[0] && wrEn && wrAddr == '0 && !(wrEn && wrAddr == ADDR_W'(CTL_ADDR)) |=> activeCmp[CMP_W-1:0] == $past(wrData)); // R8
  AST_ANYTIME_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    ctlVal[0] |-> !reloadPending); // R9
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[0] && armWr && pt |=> !reloadPending && activeCmp[ARM_CH*CMP_W +: CMP_W] == $past(wrData)); // R10
  AST_NO_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[0] && !reloadPending && !armWr |=> $stable(activeCmp)); // R11
endmodule

bind cmpReloadTop cmpReloadChk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .peakEvt(peakEvt), .valleyEvt(valleyEvt), .peakReloadEn(peakReloadEn),
  .valleyReloadEn(valleyReloadEn), .peakIrqEvt(peakIrqEvt), .valleyIrqEvt(valleyIrqEvt),
  .ctlVal(ctlVal), .reloadPending(reloadPending), .bufferCmp(bufferCmp), .activeCmp(activeCmp)
);

// File: tb/cmpReloadTop_tb.sv
module cmpReloadTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 18;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [5:0]  ev;      // {peakEvt, peakReloadEn, valleyEvt, valleyReloadEn, peakIrqEvt, valleyIrqEvt}
    logic [7:0]  expCtl;
    logic        expPend;
    logic [63:0] expAct;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NSTEP] = '{
    '{1'b1, 3'd0, 16'h1111, 6'b000000, 8'h00, 1'b0, 64'h0, 4'd3},                    // R3
    '{1'b1, 3'd2, 16'h3333, 6'b000000, 8'h00, 1'b0, 64'h0, 4'd3},                    // R3
    '{1'b0, 3'd0, 16'h0000, 6'b110000, 8'h00, 1'b0, 64'h0, 4'd11},                   // R11
    '{1'b1, 3'd1, 16'h2222, 6'b000000, 8'h00, 1'b1, 64'h0, 4'd4},                    // R4
    '{1'b0, 3'd0, 16'h0000, 6'b000010, 8'h00, 1'b1, 64'h0, 4'd6},                    // R6
    '{1'b0, 3'd0, 16'h0000, 6'b100000, 8'h00, 1'b1, 64'h0, 4'd6},                    // R6
    '{1'b0, 3'd0, 16'h0000, 6'b001100, 8'h00, 1'b0, 64'h0000_3333_2222_1111, 4'd5},  // R5
    '{1'b1, 3'd3, 16'h4444, 6'b000000, 8'h00, 1'b0, 64'h0000_3333_2222_1111, 4'd3},  // R3
    '{1'b1, 3'd5, 16'h5555, 6'b110000, 8'h00, 1'b0, 64'h4444_3333_5555_1111, 4'd10}, // R10
    '{1'b1, 3'd4, 16'h0002, 6'b000000, 8'h02, 1'b0, 64'h4444_3333_5555_1111, 4'd1},  // R1
    '{1'b1, 3'd0, 16'h6666, 6'b000000, 8'h02, 1'b0, 64'h4444_3333_5555_1111, 4'd3},  // R3
    '{1'b1, 3'd1, 16'h7777, 6'b000000, 8'h02, 1'b1, 64'h4444_3333_5555_1111, 4'd4},  // R4
    '{1'b0, 3'd0, 16'h0000, 6'b110000, 8'h02, 1'b1, 64'h4444_3333_5555_1111, 4'd7},  // R7
    '{1'b0, 3'd0, 16'h0000, 6'b000001, 8'h02, 1'b0, 64'h4444_3333_7777_6666, 4'd7},  // R7
    '{1'b1, 3'd1, 16'h8888, 6'b000000, 8'h02, 1'b1, 64'h4444_3333_7777_6666, 4'd4},  // R4
    '{1'b1, 3'd4, 16'h0003, 6'b000000, 8'h03, 1'b0, 64'h4444_3333_7777_6666, 4'd9},  // R9
    '{1'b1, 3'd2, 16'h9999, 6'b000000, 8'h03, 1'b0, 64'h4444_9999_7777_6666, 4'd8},  // R8
    '{1'b0, 3'd0, 16'h0000, 6'b000010, 8'h03, 1'b0, 64'h4444_9999_7777_6666, 4'd8}   // R8
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic peakEvt = 0, valleyEvt = 0, peakReloadEn = 0, valleyReloadEn = 0, peakIrqEvt = 0, valleyIrqEvt = 0;
  logic [7:0] ctlVal;
  logic reloadPending;
  logic [63:0] bufferCmp, activeCmp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpReloadTop dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .peakEvt(peakEvt), .valleyEvt(valleyEvt), .peakReloadEn(peakReloadEn),
    .valleyReloadEn(valleyReloadEn), .peakIrqEvt(peakIrqEvt), .valleyIrqEvt(valleyIrqEvt),
    .ctlVal(ctlVal), .reloadPending(reloadPending), .bufferCmp(bufferCmp), .activeCmp(activeCmp)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [15:0] d, input logic [5:0] ev);
    wrEn = w; wrAddr = a; wrData = d;
    {peakEvt, peakReloadEn, valleyEvt, valleyReloadEn, peakIrqEvt, valleyIrqEvt} = ev;
    @(posedge clk);
    #2;
    wrEn = 0; {peakEvt, peakReloadEn, valleyEvt, valleyReloadEn, peakIrqEvt, valleyIrqEvt} = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 / R2: reset state
    check("R1", {56'h0, ctlVal}, 64'h0);
    check("R2", {63'h0, reloadPending}, 64'h0);
    check("R2", activeCmp, 64'h0);
    check("R2", bufferCmp, 64'h0);
    rstN = 1'b1;
    @(posedge clk); #2;

    for (int i = 0; i < NSTEP; i++) begin
      string tag;
      step(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].ev);
      tag = $sformatf("R%0d step %0d", VECS[i].req, i);
      check(tag, {56'h0, ctlVal}, {56'h0, VECS[i].expCtl});
      check(tag, {63'h0, reloadPending}, {63'h0, VECS[i].expPend});
      check(tag, activeCmp, VECS[i].expAct);
    end

    // R3: buffers hold every write, including ones not yet transferred
    check("R3 buffers", bufferCmp, 64'h4444_9999_8888_6666);

    // R1: upper bits read zero
    step(1, 3'd4, 16'hFFFF, 6'b0);
    check("R1 upper", {56'h0, ctlVal}, 64'h03);
    // back to reload mode, arm, then leave via anytime write: R9
    step(1, 3'd4, 16'h0000, 6'b0);
    check("R1 clear", {56'h0, ctlVal}, 64'h00);
    step(1, 3'd5, 16'hABCD, 6'b0);
    check("R4 alias arm", {63'h0, reloadPending}, 64'h1);
    check("R4 alias buf", bufferCmp[31:16], 64'hABCD);
    step(1, 3'd4, 16'h0001, 6'b0);
    check("R9 clear pend", {63'h0, reloadPending}, 64'h0);
    check("R9 act kept", activeCmp, 64'h4444_9999_7777_6666);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule